// File: doc/BRIEF.md
# Peripheral privilege access filter

The filter sits on the path from a bus master to a bank of peripheral register slots. Every access carries a slot number, a register offset and a privilege attribute. The block checks the access against a per-slot policy bit. When filtering is on and an unprivileged access targets a slot marked privileged-only, the access is stopped before it reaches the peripheral. The master still gets a normal one-cycle completion, and a read returns zero. The slot number of the first such fault is latched, and an interrupt flag is raised for software to inspect.

The filter's own configuration registers occupy the highest slot and obey that slot's policy bit. Privileged code can therefore lock the configuration against unprivileged writers. Accesses to the configuration slot are served internally and never appear on the peripheral side. The address decoder that produces the slot number, and the peripherals themselves, are outside the block.

Top module: `priv_filter_top`

## Requirements
- R1: When the filter is enabled, the slot's policy bit is 1 and `m_priv` is 0, the access is blocked: `p_sel` and `p_write` stay 0 for that access.
- R2: A blocked access completes in its own cycle (`m_ready` = 1), and `m_rdata` is all zeros.
- R3: An access that is not blocked and targets any slot other than the configuration slot is forwarded. `p_sel` = 1, `p_write` = `m_write`, slot/offset/write data are passed on, and `m_rdata`/`m_ready` follow `p_rdata`/`p_ready`.
- R4: Slots 0 to 31 take their policy bit from bit `slot` of the low policy word (offset 0). Slots 32 to 63 take theirs from bit `slot-32` of the high policy word (offset 1).
- R5: Bit 0 of the control register (offset 2) enables the filter. While it is 0, every access is allowed whatever the policy bits.
- R6: After reset the filter is enabled, both policy words are 0, the fault flag is 0, the interrupt enable is 0 and `irq` is 0.
- R7: A blocked access sets the fault flag (bit 0 at offset 3). When the flag was clear, it also stores the slot number in the fault-ID register (offset 7). Both are visible from the next cycle.
- R8: While the fault flag stays set, later blocked accesses leave the fault-ID register unchanged.
- R9: Writing 1 to bit 0 at offset 4 sets the flag. Writing 1 to bit 0 at offset 5 clears it. Writing 0 to either offset changes nothing.
- R10: `irq` equals the fault flag AND the interrupt enable bit (bit 0 at offset 6). Writing the enable does not clear a pending flag, so enabling over a pending flag raises `irq` at once.
- R11: The configuration registers are slot 63 (slot `NUM_SLOTS-1`) and are guarded by that slot's policy bit. A blocked configuration write changes no register. No configuration access asserts `p_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_sel | input | 1 | Master access request, one cycle per access |
| m_write | input | 1 | 1 = write, 0 = read |
| m_priv | input | 1 | Access carries the privileged attribute |
| m_slot | input | SLOT_W (6) | Target slot number |
| m_addr | input | ADDR_W (8) | Register word offset within the slot |
| m_wdata | input | 32 | Write data |
| m_rdata | output | 32 | Read data returned to the master |
| m_ready | output | 1 | Access completes this cycle |
| p_sel | output | 1 | Select toward the peripheral bank |
| p_write | output | 1 | Write strobe toward the peripheral bank |
| p_slot | output | SLOT_W (6) | Slot forwarded to the peripheral bank |
| p_addr | output | ADDR_W (8) | Offset forwarded to the peripheral bank |
| p_wdata | output | 32 | Write data forwarded to the peripheral bank |
| p_rdata | input | 32 | Read data from the selected peripheral |
| p_ready | input | 1 | Completion from the selected peripheral |
| irq | output | 1 | Privilege-fault interrupt |

## Verification
The bench uses the default build of 64 slots and 8-bit offsets. Both policy words are therefore fully populated, and the configuration slot falls on bit 31 of the high word. That makes the lock case reachable, where unprivileged code is shut out of the filter's own registers. It also lets randomly chosen slots land on either word, so the split between the two words is exercised on both sides of the boundary.

// File: rtl/priv_filter_pkg.sv
// Shared definitions for the privilege access filter.
// Assumes 32-bit register words and at most two policy words.
package priv_filter_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned POL_WORDS = 2;

    // Word offsets of the configuration registers inside the config slot.
    typedef enum logic [2:0] {
        CFG_POL_LO   = 3'd0,
        CFG_POL_HI   = 3'd1,
        CFG_CTRL     = 3'd2,
        CFG_FLAG     = 3'd3,
        CFG_FLAG_SET = 3'd4,
        CFG_FLAG_CLR = 3'd5,
        CFG_IEN      = 3'd6,
        CFG_FAULT_ID = 3'd7
    } cfg_reg_e;
endpackage

// File: rtl/access_gate.sv
// Access decision and response steering.
// Decides per access whether it is blocked, forwards allowed peripheral
// accesses and answers blocked or configuration accesses itself.
// Assumes one-cycle accesses: a blocked or config access completes at once.
module access_gate
    import priv_filter_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 64,
    parameter int unsigned SLOT_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 m_sel,
    input  logic                 m_write,
    input  logic                 m_priv,
    input  logic [SLOT_W-1:0]    m_slot,
    input  logic [NUM_SLOTS-1:0] policy,
    input  logic                 filt_en,
    input  logic [WORD_W-1:0]    p_rdata,
    input  logic                 p_ready,
    input  logic [WORD_W-1:0]    cfg_rdata,
    output logic                 p_sel,
    output logic                 p_write,
    output logic [WORD_W-1:0]    m_rdata,
    output logic                 m_ready,
    output logic                 cfg_sel,
    output logic                 fault_evt
);
    localparam logic [SLOT_W-1:0] CFG_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic blocked;
    logic is_cfg;

    // Policy lookup: privileged-only slot hit by an unprivileged access.
    always_comb begin
        blocked = filt_en & policy[m_slot] & ~m_priv;
        is_cfg  = (m_slot == CFG_SLOT);
    end

    // Select, strobe and fault event generation.
    always_comb begin
        p_sel     = m_sel & ~blocked & ~is_cfg;
        p_write   = p_sel & m_write;
        cfg_sel   = m_sel & ~blocked & is_cfg;
        fault_evt = m_sel & blocked;
    end

    // Response steering back to the master.
    always_comb begin
        if (blocked) begin
            m_rdata = '0;
            m_ready = 1'b1;
        end else if (is_cfg) begin
            m_rdata = cfg_rdata;
            m_ready = 1'b1;
        end else begin
            m_rdata = p_rdata;
            m_ready = p_ready;
        end
    end

    // R5
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_sel && !filt_en && m_slot != CFG_SLOT) |-> p_sel);
endmodule

// File: rtl/fault_capture.sv
// Fault flag and fault-ID capture.
// Sets the flag on a blocked access or a software set and clears it on a
// software clear. Keeps the first faulting slot while the flag stays set.
// Assumes a software clear never coincides with a fault (single master).
module fault_capture #(
    parameter int unsigned SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_evt,
    input  logic [SLOT_W-1:0] fault_slot,
    input  logic              sw_set,
    input  logic              sw_clr,
    output logic              flag_q,
    output logic [SLOT_W-1:0] fault_id_q
);
    // Sticky fault flag with software set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (sw_clr)             flag_q <= 1'b0;
        else if (fault_evt || sw_set) flag_q <= 1'b1;
    end

    // Capture the first faulting slot while the flag is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fault_id_q <= '0;
        else if (fault_evt && !flag_q)  fault_id_q <= fault_slot;
    end

    // R7
    fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> flag_q);
    // R8
    first_id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clr) |=> (fault_id_q == $past(fault_id_q)));
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clr) |=> flag_q);
endmodule

// File: rtl/policy_regs.sv
// Configuration register file of the filter.
// Holds the policy words, the filter enable and the interrupt enable.
// Decodes the write-one set/clear strobes and serves reads of all registers.
// Assumes cfg_sel already carries the policy decision for the config slot.
module policy_regs
    import priv_filter_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 64,
    parameter int unsigned SLOT_W    = 6,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_sel,
    input  logic                 m_write,
    input  logic [ADDR_W-1:0]    m_addr,
    input  logic [WORD_W-1:0]    m_wdata,
    input  logic                 flag_q,
    input  logic [SLOT_W-1:0]    fault_id_q,
    output logic [NUM_SLOTS-1:0] policy,
    output logic                 filt_en,
    output logic                 ien_q,
    output logic                 sw_set,
    output logic                 sw_clr,
    output logic [WORD_W-1:0]    cfg_rdata
);
    logic                        in_map;
    cfg_reg_e                    reg_idx;
    logic                        wr;
    logic [WORD_W-1:0]           pol_q [POL_WORDS];
    logic [POL_WORDS*WORD_W-1:0] pol_flat;

    // Offset decode: only the first eight words hold registers.
    always_comb begin
        in_map  = ((m_addr >> 3) == '0);
        reg_idx = cfg_reg_e'(m_addr[2:0]);
        wr      = cfg_sel & m_write & in_map;
    end

    // One register per policy word, word w at offset w.
    for (genvar w = 0; w < POL_WORDS; w++) begin : g_pol
        always_ff @(posedge clk) begin
            if (!rst_n)                          pol_q[w] <= '0;
            else if (wr && reg_idx == 3'(w))     pol_q[w] <= m_wdata;
        end
        assign pol_flat[w*WORD_W +: WORD_W] = pol_q[w];
    end
    assign policy = pol_flat[NUM_SLOTS-1:0];

    // Filter enable, on out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       filt_en <= 1'b1;
        else if (wr && reg_idx == CFG_CTRL) filt_en <= m_wdata[0];
    end

    // Interrupt enable, off out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ien_q <= 1'b0;
        else if (wr && reg_idx == CFG_IEN) ien_q <= m_wdata[0];
    end

    // Write-one strobes toward the fault flag.
    always_comb begin
        sw_set = wr && reg_idx == CFG_FLAG_SET && m_wdata[0];
        sw_clr = wr && reg_idx == CFG_FLAG_CLR && m_wdata[0];
    end

    // Read mux of the configuration slot.
    always_comb begin
        cfg_rdata = '0;
        if (in_map) begin
            unique case (reg_idx)
                CFG_POL_LO:   cfg_rdata = pol_q[0];
                CFG_POL_HI:   cfg_rdata = pol_q[1];
                CFG_CTRL:     cfg_rdata[0] = filt_en;
                CFG_FLAG:     cfg_rdata[0] = flag_q;
                CFG_IEN:      cfg_rdata[0] = ien_q;
                CFG_FAULT_ID: cfg_rdata[SLOT_W-1:0] = fault_id_q;
                default:      cfg_rdata = '0;
            endcase
        end
    end

    // R11
    blocked_cfg_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> $stable(filt_en) && $stable(ien_q));
endmodule

// File: rtl/priv_filter_top.sv
// Peripheral privilege access filter, top level.
// Connects the access gate, the configuration registers and the fault
// capture, and forms the interrupt. Assumes NUM_SLOTS is 33..64, so the
// config slot lies in the high policy word.
module priv_filter_top
    import priv_filter_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 64,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_sel,
    input  logic              m_write,
    input  logic              m_priv,
    input  logic [SLOT_W-1:0] m_slot,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [31:0]       m_wdata,
    output logic [31:0]       m_rdata,
    output logic              m_ready,
    output logic              p_sel,
    output logic              p_write,
    output logic [SLOT_W-1:0] p_slot,
    output logic [ADDR_W-1:0] p_addr,
    output logic [31:0]       p_wdata,
    input  logic [31:0]       p_rdata,
    input  logic              p_ready,
    output logic              irq
);
    logic [NUM_SLOTS-1:0] policy;
    logic                 filt_en, ien_q, sw_set, sw_clr;
    logic                 cfg_sel, fault_evt, flag_q;
    logic [SLOT_W-1:0]    fault_id_q;
    logic [WORD_W-1:0]    cfg_rdata;

    access_gate #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_gate (
        .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_write(m_write),
        .m_priv(m_priv), .m_slot(m_slot), .policy(policy), .filt_en(filt_en),
        .p_rdata(p_rdata), .p_ready(p_ready), .cfg_rdata(cfg_rdata),
        .p_sel(p_sel), .p_write(p_write), .m_rdata(m_rdata),
        .m_ready(m_ready), .cfg_sel(cfg_sel), .fault_evt(fault_evt)
    );

    policy_regs #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .m_write(m_write),
        .m_addr(m_addr), .m_wdata(m_wdata), .flag_q(flag_q),
        .fault_id_q(fault_id_q), .policy(policy), .filt_en(filt_en),
        .ien_q(ien_q), .sw_set(sw_set), .sw_clr(sw_clr), .cfg_rdata(cfg_rdata)
    );

    fault_capture #(.SLOT_W(SLOT_W)) i_fault (
        .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .fault_slot(m_slot),
        .sw_set(sw_set), .sw_clr(sw_clr), .flag_q(flag_q),
        .fault_id_q(fault_id_q)
    );

    // Pass-through of the non-strobe request fields.
    always_comb begin
        p_slot  = m_slot;
        p_addr  = m_addr;
        p_wdata = m_wdata;
    end

    // Interrupt: pending flag masked by the enable.
    assign irq = flag_q & ien_q;

    // R1
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_sel && filt_en && policy[m_slot] && !m_priv) |-> (!p_sel && !p_write));
    // R2
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_sel && filt_en && policy[m_slot] && !m_priv) |-> (m_ready && m_rdata == '0));
    // R10
    irq_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !sw_clr && cfg_sel && m_write && m_addr == ADDR_W'(CFG_IEN) && m_wdata[0]) |=> irq);
endmodule

// File: tb/test_priv_filter_top.sv
`timescale 1ns/1ps
module test_priv_filter_top;
    localparam int NS = 64;
    localparam int SW = 6;
    localparam int AW = 8;

    logic clk = 0, rst_n = 0;
    logic m_sel = 0, m_write = 0, m_priv = 0;
    logic [SW-1:0] m_slot = '0;
    logic [AW-1:0] m_addr = '0;
    logic [31:0] m_wdata = '0, m_rdata, p_wdata, p_rdata;
    logic m_ready, p_sel, p_write, p_ready = 1, irq;
    logic [SW-1:0] p_slot;
    logic [AW-1:0] p_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference state
    logic [63:0] mpol;
    logic men, mflag, mien;
    logic [SW-1:0] mfid;

    always #2.5 clk = ~clk;

    assign p_rdata = {8'hA5, 2'b00, p_slot, 8'h3C, p_addr};

    priv_filter_top i_priv_filter_top (
        .clk(clk), .rst_n(rst_n), .m_sel(m_sel), .m_write(m_write),
        .m_priv(m_priv), .m_slot(m_slot), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .p_sel(p_sel), .p_write(p_write),
        .p_slot(p_slot), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .p_ready(p_ready), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cfg_read(input logic [AW-1:0] a);
        if (a > 7) return 32'h0;
        case (a[2:0])
            3'd0: return mpol[31:0];
            3'd1: return mpol[63:32];
            3'd2: return {31'h0, men};
            3'd3: return {31'h0, mflag};
            3'd6: return {31'h0, mien};
            3'd7: return {26'h0, mfid};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] periph_data(input logic [SW-1:0] s, input logic [AW-1:0] a);
        return {8'hA5, 2'b00, s, 8'h3C, a};
    endfunction

    // One single-cycle access, checked against the reference model.
    task automatic acc(input logic [SW-1:0] s, input logic [AW-1:0] a, input bit wr,
                       input bit pr, input logic [31:0] wd, input bit rdy);
        bit blk, cfg, exp_psel, exp_rdy;
        logic [31:0] exp_rd;
        @(negedge clk);
        m_sel = 1; m_slot = s; m_addr = a; m_write = wr; m_priv = pr; m_wdata = wd; p_ready = rdy;
        blk = men && mpol[s] && !pr;
        cfg = (s == SW'(NS-1));
        exp_psel = !blk && !cfg;
        exp_rdy = (blk || cfg) ? 1'b1 : rdy;
        exp_rd = blk ? 32'h0 : (cfg ? cfg_read(a) : periph_data(s, a));
        #1;
        chk(irq == (mflag && mien), "R10 irq", {31'h0, irq}, {31'h0, mflag && mien});
        if (blk) begin
            chk(!p_sel && !p_write, "R1 blocked strobes", {30'h0, p_sel, p_write}, 32'h0);
            chk(m_rdata == 0 && m_ready, "R2 blocked response", m_rdata, 32'h0);
        end else if (cfg) begin
            chk(!p_sel, "R11 cfg not forwarded", {31'h0, p_sel}, 32'h0);
            chk(m_rdata == exp_rd && m_ready, "R11 cfg read", m_rdata, exp_rd);
        end else begin
            chk(p_sel && p_write == wr && p_slot == s && p_addr == a && p_wdata == wd,
                "R3 forward", {p_sel, p_write, 6'h0, p_slot, 8'h0, p_addr}, {1'b1, wr, 6'h0, s, 8'h0, a});
            chk(m_rdata == exp_rd && m_ready == exp_rdy, "R3 response", m_rdata, exp_rd);
        end
        @(posedge clk);
        if (blk) begin
            if (!mflag) mfid = s;
            mflag = 1;
        end else if (cfg && wr && a <= 7) begin
            case (a[2:0])
                3'd0: mpol[31:0] = wd;
                3'd1: mpol[63:32] = wd;
                3'd2: men = wd[0];
                3'd4: if (wd[0]) mflag = 1;
                3'd5: if (wd[0]) mflag = 0;
                3'd6: mien = wd[0];
                default: ;
            endcase
        end
        @(negedge clk);
        m_sel = 0; m_write = 0;
    endtask

    task automatic expect_cfg(input logic [2:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        m_sel = 1; m_slot = 6'd63; m_addr = {5'h0, a}; m_write = 0; m_priv = 1;
        #1;
        chk(m_rdata == e, req, m_rdata, e);
        @(negedge clk);
        m_sel = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D2C));
        mpol = '0; men = 1; mflag = 0; mien = 0; mfid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R6 reset state
        expect_cfg(3'd2, 32'h1, "R6 enable after reset");
        expect_cfg(3'd0, 32'h0, "R6 pol lo after reset");
        expect_cfg(3'd1, 32'h0, "R6 pol hi after reset");
        expect_cfg(3'd3, 32'h0, "R6 flag after reset");
        expect_cfg(3'd6, 32'h0, "R6 ien after reset");
        chk(irq == 0, "R6 irq after reset", {31'h0, irq}, 32'h0);

        // R3 unprotected unprivileged access, stalled and ready peripheral
        acc(6'd5, 8'h10, 0, 0, 0, 1);
        acc(6'd5, 8'h11, 1, 0, 32'hDEAD0001, 0);

        // R4 protect slot 5 (low word) and slot 40 (high word bit 8)
        acc(6'd63, 8'd0, 1, 1, 32'h0000_0020, 1);
        acc(6'd63, 8'd1, 1, 1, 32'h0000_0100, 1);
        acc(6'd5, 8'h02, 0, 0, 0, 1);    // R1 R2 blocked read
        expect_cfg(3'd3, 32'h1, "R7 flag after fault");
        expect_cfg(3'd7, 32'd5, "R7 fault id");
        acc(6'd40, 8'h03, 1, 0, 32'h1234, 1); // R4 high word blocks
        expect_cfg(3'd7, 32'd5, "R8 first id kept");
        acc(6'd8, 8'h04, 0, 0, 0, 1);    // R4 low bit 8 clear: passes
        acc(6'd5, 8'h05, 0, 1, 0, 1);    // R3 privileged passes

        // R10 enabling over a pending flag
        acc(6'd63, 8'd6, 1, 1, 32'h1, 1);
        @(negedge clk);
        chk(irq == 1, "R10 irq on enable", {31'h0, irq}, 32'h1);
        expect_cfg(3'd3, 32'h1, "R10 flag kept by ien write");

        // R9 zero writes ignored, one writes act
        acc(6'd63, 8'd5, 1, 1, 32'h0, 1);
        expect_cfg(3'd3, 32'h1, "R9 clear with 0 ignored");
        acc(6'd63, 8'd5, 1, 1, 32'h1, 1);
        expect_cfg(3'd3, 32'h0, "R9 clear");
        acc(6'd63, 8'd4, 1, 1, 32'h0, 1);
        expect_cfg(3'd3, 32'h0, "R9 set with 0 ignored");
        acc(6'd63, 8'd4, 1, 1, 32'h1, 1);
        expect_cfg(3'd3, 32'h1, "R9 set");
        acc(6'd63, 8'd5, 1, 1, 32'h1, 1);

        // R5 filter disabled
        acc(6'd63, 8'd2, 1, 1, 32'h0, 1);
        acc(6'd5, 8'h06, 1, 0, 32'hABCD, 1);
        acc(6'd40, 8'h07, 0, 0, 0, 1);
        expect_cfg(3'd3, 32'h0, "R5 no fault while disabled");
        acc(6'd63, 8'd2, 1, 1, 32'h1, 1);

        // R11 lock the config slot
        acc(6'd63, 8'd1, 1, 1, 32'h8000_0100, 1);
        acc(6'd63, 8'd6, 1, 0, 32'h0, 1);
        expect_cfg(3'd6, 32'h1, "R11 locked ien unchanged");
        expect_cfg(3'd7, 32'd63, "R11 cfg fault id");
        acc(6'd63, 8'd2, 1, 0, 32'h0, 1);
        expect_cfg(3'd2, 32'h1, "R11 locked enable unchanged");
        acc(6'd63, 8'd5, 1, 1, 32'h1, 1);
        acc(6'd63, 8'd1, 1, 1, 32'h0, 1);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [SW-1:0] s;
            logic [AW-1:0] a;
            s = ($urandom % 8 == 0) ? 6'd63 : 6'($urandom);
            a = (s == 6'd63) ? AW'($urandom % 9) : AW'($urandom);
            if (s == 6'd63 && a == 8'd2)
                acc(s, a, $urandom % 2, $urandom % 2, {31'h0, ($urandom % 4) != 0}, 1);
            else
                acc(s, a, $urandom % 2, $urandom % 2, $urandom, $urandom % 2);
        end
        expect_cfg(3'd3, {31'h0, mflag}, "R7 flag after random");
        expect_cfg(3'd7, {26'h0, mfid}, "R8 fault id after random");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule